// File: doc/BRIEF.md
# Inhibitable Cycle Counter with Sticky Overflow

This block is the free-running cycle counter of a performance monitor inside an I/O address-translation unit. A count of `CNT_W` bits (63 by default) advances once per clock. A small register interface lets software read and load the counter word, set or clear an inhibit bit that freezes the count, and read an overflow-status register. The counter word is one bit wider than the count. Its top bit is a sticky overflow flag, and the low bits hold the count.

When the count rolls over from all ones to zero, the block looks at the overflow-status bit. If that bit is clear, the block sets it and the flag in the counter word, and it emits a one-cycle performance-monitor interrupt. If the status bit is already set, the rollover leaves both flags set and raises no interrupt. Software acknowledges an overflow by loading the counter word with its top bit at zero.

The block is built around two small state machines. The run machine has the states `CNT_RUN` and `CNT_HOLD`. An inhibit write with bit 0 set takes `CNT_RUN` to `CNT_HOLD` (transition *freeze*). An inhibit write with bit 0 clear takes `CNT_HOLD` back to `CNT_RUN` (transition *resume*). The overflow machine has the states `OVF_IDLE` and `OVF_RAISED`. A rollover in `OVF_IDLE` takes it to `OVF_RAISED` and fires the interrupt (transition *raise*). A counter-word load with the top bit at zero takes `OVF_RAISED` back to `OVF_IDLE` (transition *acknowledge*).

Top module: `cyc_counter_top`

## Requirements
- R1: After reset the count is 0, the counter-word flag is 0, the status bit is 0, the inhibit bit reads 0 and `pm_irq` is low.
- R2: While the inhibit bit is clear, the count rises by one on every clock edge. The count is read with `rd_sel`=0 in bits `CNT_W-1:0`.
- R3: A write with `wr_sel`=1 stores `wr_data[0]` as the inhibit bit, which reads back with `rd_sel`=1 in bit 0. While it is 1, the count holds its value. The edge that performs the write still follows the state held before that write.
- R4: Clearing the inhibit bit makes counting resume from the held value, with no jump.
- R5: A write with `wr_sel`=0 loads the count from `wr_data[CNT_W-1:0]` and the counter-word flag from `wr_data[CNT_W]`. The load takes priority over the increment on that edge, and it also works while the counter is inhibited.
- R6: When the count rolls over from all ones, it continues from zero and does not saturate.
- R7: On a rollover with the status bit clear, status bit 0 (`rd_sel`=2) and the counter-word flag (bit `CNT_W` with `rd_sel`=0) are set on the rollover edge. `pm_irq` is high for exactly the one cycle that follows that edge.
- R8: On a rollover with the status bit already set, no interrupt is raised and both flags stay set.
- R9: A counter-word load with `wr_data[CNT_W]`=0 clears the status bit. A load with that bit at 1 leaves the status bit as it was.
- R10: Writes with `wr_sel`=2 or 3 change nothing, and reads with `rd_sel`=3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter word, 1 inhibit, 2 status (read-only), 3 none |
| wr_data | input | CNT_W+1 | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | CNT_W+1 | Combinational read data |
| pm_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench builds the block with `CNT_W`=5, so the count spans only 32 values and rolls over after at most 32 cycles. This makes a full sweep practical: the bench loads every one of the 32 count values with both flag settings, and each run from a load crosses a rollover. That reaches both the raise path and the already-raised path many times. Because the count is short, the bench can also place inhibit holds of several lengths, loads made during a hold, and acknowledge writes on either side of a rollover, and compare each cycle against an arithmetic model.

// File: rtl/cyc_hpm_pkg.sv
package cyc_hpm_pkg;

    // Register select encoding shared by the read and write ports.
    typedef enum logic [1:0] {
        SEL_WORD    = 2'd0,
        SEL_INHIBIT = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // Run/hold machine.
    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HOLD = 1'b1
    } run_state_e;

    // Overflow status machine; OVF_RAISED is the sticky status bit.
    typedef enum logic {
        OVF_IDLE   = 1'b0,
        OVF_RAISED = 1'b1
    } ovf_state_e;

endpackage

// File: rtl/cyc_run_fsm.sv
module cyc_run_fsm
    import cyc_hpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inh_wr,
    input  logic inh_val,
    output logic count_en,
    output logic inhibit_q
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:  if (inh_wr && inh_val)  state_d = CNT_HOLD;  // freeze
            CNT_HOLD: if (inh_wr && !inh_val) state_d = CNT_RUN;   // resume
            default:  state_d = CNT_RUN;
        endcase
    end

    always_comb begin
        count_en  = 1'b0;
        inhibit_q = 1'b0;
        unique case (state_q)
            CNT_RUN:  count_en  = 1'b1;
            CNT_HOLD: inhibit_q = 1'b1;
            default: begin
                count_en  = 1'b0;
                inhibit_q = 1'b0;
            end
        endcase
    end

    AST_INH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_wr && inh_val) |=> (!count_en && inhibit_q)); // R3
    AST_INH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_wr && !inh_val) |=> (count_en && !inhibit_q)); // R4

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (load)     count_q <= load_val;
        else if (count_en) count_q <= count_q + CNT_ONE;
    end

    assign count = count_q;
    // A rollover occurs only on an increment edge that starts at all ones.
    assign wrap  = count_en && !load && (count_q == CNT_MAX);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !load) |=> (count_q == CNT_W'($past(count_q) + CNT_ONE))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !load) |=> $stable(count_q)); // R3
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val))); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count_q == '0)); // R6

endmodule

// File: rtl/cyc_ovf_fsm.sv
module cyc_ovf_fsm
    import cyc_hpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic word_wr,
    input  logic word_msb,
    output logic status,
    output logic word_flag,
    output logic irq
);

    ovf_state_e state_q, state_d;
    logic       flag_q;
    logic       irq_q;
    logic       raise;

    assign raise = (state_q == OVF_IDLE) && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE:   if (wrap)                  state_d = OVF_RAISED; // raise
            OVF_RAISED: if (word_wr && !word_msb)  state_d = OVF_IDLE;   // acknowledge
            default:    state_d = OVF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= raise;
            if (word_wr)    flag_q <= word_msb;
            else if (raise) flag_q <= 1'b1;
        end
    end

    always_comb begin
        status = 1'b0;
        unique case (state_q)
            OVF_IDLE:   status = 1'b0;
            OVF_RAISED: status = 1'b1;
            default:    status = 1'b0;
        endcase
    end

    assign word_flag = flag_q;
    assign irq       = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && word_flag)); // R7
    AST_NO_REPEAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status && wrap) |=> (!irq && status && word_flag)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !word_msb) |=> (!status && !word_flag)); // R9
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !(word_wr && !word_msb)) |=> status); // R9

endmodule

// File: rtl/cyc_counter_top.sv
module cyc_counter_top
    import cyc_hpm_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W:0]    wr_data,
    input  logic [1:0]        rd_sel,
    output logic [CNT_W:0]    rd_data,
    output logic              pm_irq
);

    localparam int WORD_W = CNT_W + 1;

    reg_sel_e         wsel, rsel;
    logic             word_wr, inh_wr;
    logic             count_en, inhibit_q;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             status, word_flag;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_comb begin
        word_wr = 1'b0;
        inh_wr  = 1'b0;
        unique case (wsel)
            SEL_WORD:    word_wr = wr_en;
            SEL_INHIBIT: inh_wr  = wr_en;
            SEL_STATUS:  word_wr = 1'b0;
            SEL_NONE:    inh_wr  = 1'b0;
            default:     word_wr = 1'b0;
        endcase
    end

    cyc_run_fsm u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .inh_wr    (inh_wr),
        .inh_val   (wr_data[0]),
        .count_en  (count_en),
        .inhibit_q (inhibit_q)
    );

    cyc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .load     (word_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .count    (count),
        .wrap     (wrap)
    );

    cyc_ovf_fsm u_ovf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .word_wr   (word_wr),
        .word_msb  (wr_data[CNT_W]),
        .status    (status),
        .word_flag (word_flag),
        .irq       (pm_irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_WORD:    rd_data = {word_flag, count};
            SEL_INHIBIT: rd_data = {{(WORD_W-1){1'b0}}, inhibit_q};
            SEL_STATUS:  rd_data = {{(WORD_W-1){1'b0}}, status};
            SEL_NONE:    rd_data = '0;
            default:     rd_data = '0;
        endcase
    end

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pm_irq |-> (count == '0)); // R6
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wsel == SEL_STATUS) && !status) |=> !pm_irq || ($past(wrap))); // R10

endmodule

// File: tb/cyc_counter_top_tb_top.sv
`timescale 1ns/1ps
module cyc_counter_top_tb_top;

    localparam int CW = 5;
    localparam int WW = CW + 1;
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [WW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [WW-1:0] rd_data;
    logic          pm_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state, computed from the requirements.
    logic [CW-1:0] m_cnt;
    logic m_flag, m_stat, m_inh, m_irq;

    always #2.5 clk = ~clk;

    cyc_counter_top #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pm_irq(pm_irq)
    );

    always @(posedge clk) begin
        logic ld, wrp;
        if (!rst_n) begin
            m_cnt <= '0; m_flag <= 1'b0; m_stat <= 1'b0; m_inh <= 1'b0; m_irq <= 1'b0;
        end else begin
            ld  = wr_en && (wr_sel == 2'd0);
            wrp = !m_inh && !ld && (m_cnt == MAXV);
            m_irq <= wrp && !m_stat;
            if (ld) begin
                m_cnt  <= wr_data[CW-1:0];
                m_flag <= wr_data[CW];
                if (!wr_data[CW]) m_stat <= 1'b0;
            end else begin
                if (!m_inh) m_cnt <= m_cnt + 1'b1;
                if (wrp && !m_stat) begin
                    m_stat <= 1'b1;
                    m_flag <= 1'b1;
                end
            end
            if (wr_en && (wr_sel == 2'd1)) m_inh <= wr_data[0];
        end
    end

    function automatic logic [WW-1:0] m_read(input int sel);
        case (sel)
            0: return {m_flag, m_cnt};
            1: return {{(WW-1){1'b0}}, m_inh};
            2: return {{(WW-1){1'b0}}, m_stat};
            default: return '0;
        endcase
    endfunction

    task automatic chk_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            logic [WW-1:0] e;
            rd_sel = 2'(s);
            #0.2;
            e = m_read(s);
            n_chk++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s: read sel %0d got %h expected %h", tag, s, rd_data, e);
            end
        end
        n_chk++;
        if (pm_irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s: pm_irq got %b expected %b", tag, pm_irq, m_irq);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, then check.
    task automatic cyc(input logic we, input logic [1:0] ws, input logic [WW-1:0] wd,
                       input string tag);
        wr_en = we; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk_all("R1 reset");
        rst_n = 1'b1;
        cyc(1'b0, 2'd0, '0, "R1 R2 first count");

        // R5/R2/R6/R7/R8: every load value with both flag settings, each run crossing a rollover.
        for (int f = 0; f < 2; f++) begin
            for (int v = 0; v < (1 << CW); v++) begin
                cyc(1'b1, 2'd0, {f[0], v[CW-1:0]}, "R5 load");
                for (int k = 0; k < 36; k++)
                    cyc(1'b0, 2'd0, '0, "R2 R6 R7 R8 run");
            end
        end

        // R3/R4: holds of several lengths, a load during a hold, then resume.
        for (int h = 1; h < 7; h++) begin
            cyc(1'b1, 2'd1, WW'(1), "R3 freeze");
            for (int k = 0; k < h; k++) cyc(1'b0, 2'd0, '0, "R3 hold");
            if (h == 3) cyc(1'b1, 2'd0, {1'b1, MAXV}, "R5 load while held");
            cyc(1'b0, 2'd0, '0, "R3 hold after");
            cyc(1'b1, 2'd1, WW'(6'h3E), "R4 resume");
            for (int k = 0; k < 4; k++) cyc(1'b0, 2'd0, '0, "R4 resumed");
        end

        // R9: acknowledge with the top bit set keeps status; with it clear, clears.
        cyc(1'b1, 2'd0, {1'b0, MAXV}, "R9 prime");
        cyc(1'b0, 2'd0, '0, "R7 rollover");
        cyc(1'b0, 2'd0, '0, "R7 pulse ends");
        cyc(1'b1, 2'd0, {1'b1, CW'(7)}, "R9 keep status");
        cyc(1'b1, 2'd0, {1'b0, CW'(7)}, "R9 clear status");
        cyc(1'b0, 2'd0, '0, "R9 after clear");

        // R10: writes to the status and unused selects are ignored.
        cyc(1'b1, 2'd0, {1'b0, MAXV}, "R10 prime");
        cyc(1'b0, 2'd0, '0, "R10 raise");
        cyc(1'b1, 2'd2, '0, "R10 status write");
        cyc(1'b1, 2'd3, '1, "R10 none write");
        cyc(1'b1, 2'd2, '1, "R10 status write ones");
        for (int k = 0; k < 4; k++) cyc(1'b0, 2'd0, '0, "R10 after");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule